// File: doc/BRIEF.md
# Four-Level Page Table Walker

This block translates a 64-bit virtual address into a physical address by walking a four-level hierarchy of translation tables held in memory. A requester presents a virtual address together with a write flag and a user flag. The block checks the address for canonical form, then fetches one 8-byte entry per level through a simple memory port, starting from a root table base supplied as an input. The walk stops early when a second-level or third-level entry marks itself as a large-page leaf.

Along the way the walker keeps the usage bits in memory up to date. It sets the accessed bit of every entry it uses, and it sets the dirty bit of the leaf on a write access. Each of these updates is a write of the entry value it has just read, with the new bits ORed in. At the leaf a separate permission checker judges the access against the write and user rights gathered across all levels. The result is either a physical address or a fault code. A page fault carries the level at which the walk stopped and the cause.

The controller has six states. IDLE accepts a request: a non-canonical address goes straight to RESP, and a canonical one goes to RD_REQ. RD_REQ holds a read on the memory port and moves to RD_WAIT once the port accepts it. RD_WAIT moves to EVAL when read data arrives. EVAL can go to RESP on a fault or on a leaf that needs no update, to WR_REQ when a usage bit must be set, or back to RD_REQ for the next level. WR_REQ holds the write and, once the port accepts it, moves to RESP after a leaf or to RD_REQ after a table entry. RESP presents the result for one cycle and returns to IDLE.

Top module: `ptw_walker`

## Requirements
- R1: For a 4 KiB mapping, virtual bits 47:39, 38:30, 29:21 and 20:12 index the four tables from top to last. Each entry address is the table base plus index times 8. A table base is entry bits 51:12 followed by twelve zero bits. The physical address is last-level entry bits 51:12 followed by virtual bits 11:0.
- R2: An address whose bits 63:48 do not all equal bit 47 gives rsp_fault=1 (general protection) and starts no memory access. Canonical addresses in the upper half translate normally.
- R3: An entry with bit 0 (present) clear gives rsp_fault=2 (page fault) and rsp_cause=1. rsp_level gives the level of that entry (0 = top, 3 = last), and no further read follows.
- R4: Bit 7 (page size) set in a level-1 entry makes it a 1 GiB leaf. The physical address is then entry bits 51:30 followed by virtual bits 29:0, after two reads. The same bit set in a level-2 entry makes a 2 MiB leaf: entry bits 51:21 followed by virtual bits 20:0, after three reads.
- R5: An entry used in a walk with bit 5 (accessed) clear is written back with bit 5 set. An entry with bit 5 already set is not written. The walker never clears bit 5.
- R6: A write access sets bit 6 (dirty) in the leaf entry. A read access leaves bit 6 unchanged. Table entries above the leaf never get bit 6 from the walker.
- R7: Any of these gives rsp_fault=2, rsp_cause=2 and the entry's level: a set bit among 62:52; bit 7 set at level 0; bits 29:13 not zero in a 1 GiB leaf; bits 20:13 not zero in a 2 MiB leaf.
- R8: The access is refused with rsp_fault=2, rsp_cause=3 at the leaf's level in two cases: a write when bit 1 (writable) is clear in any entry of the walk, or a user access when bit 2 (user) is clear in any entry of the walk. No write is then made to the leaf.
- R9: After reset req_ready=1, rsp_valid=0 and mem_req_valid=0. req_ready is 0 from the cycle after a request is accepted until the response cycle has passed.
- R10: All accessed and dirty updates are accepted by the memory port before rsp_valid rises. rsp_valid is high for exactly one cycle. A successful response has rsp_fault=0 and rsp_cause=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker idle and able to accept |
| req_vaddr | input | 64 | Virtual address to translate |
| req_write | input | 1 | Access is a write |
| req_user | input | 1 | Access is from user level |
| root_base | input | 64 | Root table base; bits 51:12 are used |
| mem_req_valid | output | 1 | Memory access request |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_write | output | 1 | Request is a write |
| mem_req_addr | output | 64 | Byte address of the entry |
| mem_req_wdata | output | 64 | Entry value to write |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 64 | Read data |
| rsp_valid | output | 1 | Result valid for one cycle |
| rsp_paddr | output | 52 | Physical address |
| rsp_fault | output | 2 | 0 none, 1 general protection, 2 page fault |
| rsp_level | output | 2 | Level where a page fault was found |
| rsp_cause | output | 2 | 0 none, 1 not present, 2 reserved bit, 3 permission |

## Verification
The bench aims at the early-stop cases. A walker that ignored the page-size bit would make four reads and return a wrong frame for the 1 GiB and 2 MiB leaves. One that checked canonical form late would show memory reads on the general-protection case. The usage-bit cases give a clear-A walk and an already-set walk. A design that updated unconditionally, set dirty on reads, or answered before the write was accepted would show wrong write counts or stale entries in the memory model. The fault cases put the fault at different levels. A wrong level report, a reserved bit taken for a permission problem, or a leaf written despite a refused access all show at the response ports or in memory.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
    localparam int ENTRY_W = 64;
    localparam int BIT_P   = 0;
    localparam int BIT_RW  = 1;
    localparam int BIT_US  = 2;
    localparam int BIT_A   = 5;
    localparam int BIT_D   = 6;
    localparam int BIT_PS  = 7;

    typedef enum logic [1:0] {
        FK_NONE = 2'd0,
        FK_GP   = 2'd1,
        FK_PF   = 2'd2
    } fault_kind_t;

    typedef enum logic [1:0] {
        FC_NONE   = 2'd0,
        FC_ABSENT = 2'd1,
        FC_RSVD   = 2'd2,
        FC_PERM   = 2'd3
    } fault_cause_t;

    typedef enum logic [1:0] {
        SZ_4K = 2'd0,
        SZ_2M = 2'd1,
        SZ_1G = 2'd2
    } leaf_size_t;

    typedef enum logic [2:0] {
        S_IDLE    = 3'd0,
        S_RD_REQ  = 3'd1,
        S_RD_WAIT = 3'd2,
        S_EVAL    = 3'd3,
        S_WR_REQ  = 3'd4,
        S_RESP    = 3'd5
    } walk_state_t;
endpackage

// File: rtl/ptw_index_sel.sv
module ptw_index_sel #(
    parameter int VA_W   = 64,
    parameter int PA_W   = 52,
    parameter int LEVELS = 4,
    parameter int IDX_W  = 9,
    parameter int OFF_W  = 12,
    localparam int LVL_W = $clog2(LEVELS),
    localparam int TOP   = OFF_W + LEVELS * IDX_W
) (
    input  logic [VA_W-1:0]  vaddr,
    input  logic [LVL_W-1:0] lvl,
    input  logic [PA_W-1:0]  table_base,
    output logic [PA_W-1:0]  entry_addr,
    output logic             canonical
);
    logic [IDX_W-1:0] idx_arr [LEVELS];
    logic [IDX_W-1:0] idx;
    logic [VA_W-TOP:0] upper;

    for (genvar g = 0; g < LEVELS; g++) begin : g_idx
        assign idx_arr[g] = vaddr[TOP-1-g*IDX_W -: IDX_W];
    end

    assign upper     = vaddr[VA_W-1:TOP-1];
    assign canonical = (&upper) | ~(|upper);
    assign idx       = idx_arr[lvl];

    always_comb begin
        entry_addr = table_base + {{(PA_W-IDX_W-3){1'b0}}, idx, 3'b000};
    end
endmodule

// File: rtl/ptw_entry_decode.sv
module ptw_entry_decode
    import ptw_pkg::*;
#(
    parameter int PA_W   = 52,
    parameter int LEVELS = 4,
    parameter int OFF_W  = 12,
    localparam int LVL_W = $clog2(LEVELS)
) (
    input  logic [ENTRY_W-1:0] entry,
    input  logic [LVL_W-1:0]   lvl,
    output logic               present,
    output logic               rsvd_err,
    output logic               is_leaf,
    output leaf_size_t         leaf_size,
    output logic [PA_W-1:0]    next_base
);
    localparam logic [LVL_W-1:0] LVL_LAST = LVL_W'(LEVELS - 1);
    localparam logic [LVL_W-1:0] LVL_2M   = LVL_W'(LEVELS - 2);
    localparam logic [LVL_W-1:0] LVL_1G   = LVL_W'(LEVELS - 3);
    localparam logic [LVL_W-1:0] LVL_TOP  = '0;

    logic ps;

    assign ps        = entry[BIT_PS];
    assign present   = entry[BIT_P];
    assign next_base = {entry[PA_W-1:OFF_W], {OFF_W{1'b0}}};

    always_comb begin
        is_leaf   = 1'b0;
        leaf_size = SZ_4K;
        if (lvl == LVL_LAST) begin
            is_leaf = 1'b1;
        end else if (ps && lvl == LVL_2M) begin
            is_leaf   = 1'b1;
            leaf_size = SZ_2M;
        end else if (ps && lvl == LVL_1G) begin
            is_leaf   = 1'b1;
            leaf_size = SZ_1G;
        end
    end

    always_comb begin
        rsvd_err = |entry[ENTRY_W-2:PA_W];
        if (lvl == LVL_TOP && ps) rsvd_err = 1'b1;
        if (is_leaf && leaf_size == SZ_1G && (|entry[29:13])) rsvd_err = 1'b1;
        if (is_leaf && leaf_size == SZ_2M && (|entry[20:13])) rsvd_err = 1'b1;
    end
endmodule

// File: rtl/ptw_perm_check.sv
module ptw_perm_check (
    input  logic rw_all,
    input  logic us_all,
    input  logic is_write,
    input  logic is_user,
    output logic allowed
);
    logic write_block;
    logic user_block;

    assign write_block = is_write & ~rw_all;
    assign user_block  = is_user & ~us_all;
    assign allowed     = ~(write_block | user_block);
endmodule

// File: rtl/ptw_walker.sv
module ptw_walker
    import ptw_pkg::*;
#(
    parameter int VA_W   = 64,
    parameter int PA_W   = 52,
    parameter int LEVELS = 4,
    parameter int IDX_W  = 9,
    parameter int OFF_W  = 12,
    localparam int LVL_W = $clog2(LEVELS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [VA_W-1:0]  req_vaddr,
    input  logic             req_write,
    input  logic             req_user,
    input  logic [63:0]      root_base,
    output logic             mem_req_valid,
    input  logic             mem_req_ready,
    output logic             mem_req_write,
    output logic [63:0]      mem_req_addr,
    output logic [63:0]      mem_req_wdata,
    input  logic             mem_rsp_valid,
    input  logic [63:0]      mem_rsp_data,
    output logic             rsp_valid,
    output logic [PA_W-1:0]  rsp_paddr,
    output logic [1:0]       rsp_fault,
    output logic [LVL_W-1:0] rsp_level,
    output logic [1:0]       rsp_cause
);
    walk_state_t state_q, state_d;

    logic [VA_W-1:0]    vaddr_q;
    logic               write_q;
    logic               user_q;
    logic [LVL_W-1:0]   lvl_q;
    logic [PA_W-1:0]    base_q;
    logic [63:0]        entry_q;
    logic               rw_acc_q;
    logic               us_acc_q;
    logic               leaf_q;
    logic [PA_W-1:0]    wr_addr_q;
    logic [63:0]        wdata_q;
    fault_kind_t        fault_q;
    fault_cause_t       cause_q;
    logic [LVL_W-1:0]   flvl_q;
    logic [PA_W-1:0]    paddr_q;

    logic [PA_W-1:0]    entry_addr;
    logic               req_canon;
    logic               dummy_canon;
    logic [PA_W-1:0]    root_pa;
    logic               ent_present;
    logic               ent_rsvd;
    logic               ent_leaf;
    leaf_size_t         ent_size;
    logic [PA_W-1:0]    ent_next;
    logic               rw_all;
    logic               us_all;
    logic               perm_ok;
    logic               need_a;
    logic               need_d;
    logic [63:0]        upd_value;
    logic [PA_W-1:0]    leaf_pa;
    logic               accept;

    assign root_pa = {root_base[PA_W-1:OFF_W], {OFF_W{1'b0}}};
    assign accept  = req_valid && (state_q == S_IDLE);

    ptw_index_sel #(
        .VA_W(VA_W), .PA_W(PA_W), .LEVELS(LEVELS), .IDX_W(IDX_W), .OFF_W(OFF_W)
    ) u_idx_walk (
        .vaddr      (vaddr_q),
        .lvl        (lvl_q),
        .table_base (base_q),
        .entry_addr (entry_addr),
        .canonical  (dummy_canon)
    );

    ptw_index_sel #(
        .VA_W(VA_W), .PA_W(PA_W), .LEVELS(LEVELS), .IDX_W(IDX_W), .OFF_W(OFF_W)
    ) u_idx_req (
        .vaddr      (req_vaddr),
        .lvl        ('0),
        .table_base (root_pa),
        .entry_addr (),
        .canonical  (req_canon)
    );

    ptw_entry_decode #(
        .PA_W(PA_W), .LEVELS(LEVELS), .OFF_W(OFF_W)
    ) u_dec (
        .entry     (entry_q),
        .lvl       (lvl_q),
        .present   (ent_present),
        .rsvd_err  (ent_rsvd),
        .is_leaf   (ent_leaf),
        .leaf_size (ent_size),
        .next_base (ent_next)
    );

    assign rw_all = rw_acc_q & entry_q[BIT_RW];
    assign us_all = us_acc_q & entry_q[BIT_US];

    ptw_perm_check u_perm (
        .rw_all   (rw_all),
        .us_all   (us_all),
        .is_write (write_q),
        .is_user  (user_q),
        .allowed  (perm_ok)
    );

    assign need_a = ~entry_q[BIT_A];
    assign need_d = ent_leaf & write_q & ~entry_q[BIT_D];

    always_comb begin
        upd_value = entry_q;
        upd_value[BIT_A] = 1'b1;
        if (ent_leaf && write_q) upd_value[BIT_D] = 1'b1;
    end

    always_comb begin
        unique case (ent_size)
            SZ_1G:   leaf_pa = {entry_q[PA_W-1:30], vaddr_q[29:0]};
            SZ_2M:   leaf_pa = {entry_q[PA_W-1:21], vaddr_q[20:0]};
            default: leaf_pa = {entry_q[PA_W-1:OFF_W], vaddr_q[OFF_W-1:0]};
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: begin
                if (req_valid) state_d = req_canon ? S_RD_REQ : S_RESP;
            end
            S_RD_REQ: begin
                if (mem_req_ready) state_d = S_RD_WAIT;
            end
            S_RD_WAIT: begin
                if (mem_rsp_valid) state_d = S_EVAL;
            end
            S_EVAL: begin
                if (!ent_present || ent_rsvd) begin
                    state_d = S_RESP;
                end else if (ent_leaf) begin
                    if (!perm_ok)               state_d = S_RESP;
                    else if (need_a || need_d)  state_d = S_WR_REQ;
                    else                        state_d = S_RESP;
                end else begin
                    state_d = need_a ? S_WR_REQ : S_RD_REQ;
                end
            end
            S_WR_REQ: begin
                if (mem_req_ready) state_d = leaf_q ? S_RESP : S_RD_REQ;
            end
            S_RESP:  state_d = S_IDLE;
            default: state_d = S_IDLE;
        endcase
    end

    // Walk datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vaddr_q   <= '0;
            write_q   <= 1'b0;
            user_q    <= 1'b0;
            lvl_q     <= '0;
            base_q    <= '0;
            entry_q   <= '0;
            rw_acc_q  <= 1'b1;
            us_acc_q  <= 1'b1;
            leaf_q    <= 1'b0;
            wr_addr_q <= '0;
            wdata_q   <= '0;
            fault_q   <= FK_NONE;
            cause_q   <= FC_NONE;
            flvl_q    <= '0;
            paddr_q   <= '0;
        end else begin
            unique case (state_q)
                S_IDLE: begin
                    if (accept) begin
                        vaddr_q  <= req_vaddr;
                        write_q  <= req_write;
                        user_q   <= req_user;
                        lvl_q    <= '0;
                        base_q   <= root_pa;
                        rw_acc_q <= 1'b1;
                        us_acc_q <= 1'b1;
                        leaf_q   <= 1'b0;
                        flvl_q   <= '0;
                        paddr_q  <= '0;
                        cause_q  <= FC_NONE;
                        fault_q  <= req_canon ? FK_NONE : FK_GP;
                    end
                end
                S_RD_WAIT: begin
                    if (mem_rsp_valid) entry_q <= mem_rsp_data;
                end
                S_EVAL: begin
                    wr_addr_q <= entry_addr;
                    wdata_q   <= upd_value;
                    leaf_q    <= ent_leaf;
                    rw_acc_q  <= rw_all;
                    us_acc_q  <= us_all;
                    flvl_q    <= lvl_q;
                    if (!ent_present) begin
                        fault_q <= FK_PF;
                        cause_q <= FC_ABSENT;
                    end else if (ent_rsvd) begin
                        fault_q <= FK_PF;
                        cause_q <= FC_RSVD;
                    end else if (ent_leaf) begin
                        if (!perm_ok) begin
                            fault_q <= FK_PF;
                            cause_q <= FC_PERM;
                        end else begin
                            paddr_q <= leaf_pa;
                        end
                    end else begin
                        lvl_q  <= lvl_q + 1'b1;
                        base_q <= ent_next;
                    end
                end
                default: ;
            endcase
        end
    end

    // Outputs
    always_comb begin
        req_ready     = (state_q == S_IDLE);
        mem_req_valid = (state_q == S_RD_REQ) || (state_q == S_WR_REQ);
        mem_req_write = (state_q == S_WR_REQ);
        mem_req_addr  = '0;
        mem_req_wdata = '0;
        if (state_q == S_WR_REQ) begin
            mem_req_addr  = 64'(wr_addr_q);
            mem_req_wdata = wdata_q;
        end else if (state_q == S_RD_REQ) begin
            mem_req_addr  = 64'(entry_addr);
        end
        rsp_valid = (state_q == S_RESP);
        rsp_paddr = paddr_q;
        rsp_fault = fault_q;
        rsp_cause = cause_q;
        rsp_level = flvl_q;
    end
endmodule

// File: rtl/ptw_walker_chk.sv
module ptw_walker_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        req_valid,
    input logic        req_ready,
    input logic [63:0] req_vaddr,
    input logic        mem_req_valid,
    input logic        mem_req_ready,
    input logic        mem_req_write,
    input logic [63:0] mem_req_addr,
    input logic [63:0] mem_req_wdata,
    input logic        rsp_valid,
    input logic [1:0]  rsp_fault,
    input logic [1:0]  rsp_cause
);
    logic addr_ok;
    assign addr_ok = (req_vaddr[63:47] == {17{req_vaddr[47]}});

    // R2
    gp_no_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && !addr_ok) |=> (!mem_req_valid && rsp_valid && rsp_fault == 2'd1));

    // R3
    pf_has_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_fault == 2'd2) |-> (rsp_cause != 2'd0));

    // R5
    upd_sets_accessed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && mem_req_write) |-> mem_req_wdata[5]);

    // R9
    busy_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    // R10
    rsp_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    // R10
    no_rsp_during_mem_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> !rsp_valid);

    // R10
    ok_no_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_fault == 2'd0) |-> (rsp_cause == 2'd0));

    // R1
    mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_write)));
endmodule

bind ptw_walker ptw_walker_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_valid     (req_valid),
    .req_ready     (req_ready),
    .req_vaddr     (req_vaddr),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_req_write (mem_req_write),
    .mem_req_addr  (mem_req_addr),
    .mem_req_wdata (mem_req_wdata),
    .rsp_valid     (rsp_valid),
    .rsp_fault     (rsp_fault),
    .rsp_cause     (rsp_cause)
);

// File: tb/ptw_walker_bench.sv
module ptw_walker_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [63:0] req_vaddr = '0;
    logic        req_write = 1'b0;
    logic        req_user = 1'b0;
    logic [63:0] root_base = 64'h10000;
    logic        mem_req_valid;
    logic        mem_req_ready = 1'b0;
    logic        mem_req_write;
    logic [63:0] mem_req_addr;
    logic [63:0] mem_req_wdata;
    logic        mem_rsp_valid = 1'b0;
    logic [63:0] mem_rsp_data = '0;
    logic        rsp_valid;
    logic [51:0] rsp_paddr;
    logic [1:0]  rsp_fault;
    logic [1:0]  rsp_level;
    logic [1:0]  rsp_cause;

    int tests = 0;
    int fails = 0;
    int rd_cnt = 0;
    int wr_cnt = 0;
    bit done = 0;
    logic [63:0] mem [longint];

    logic [51:0] got_pa;
    logic [1:0]  got_fault, got_level, got_cause;

    localparam logic [63:0] T1 = 64'h11000, T2 = 64'h12000, T3 = 64'h13000;
    localparam logic [63:0] FP = 64'h1, FW = 64'h2, FU = 64'h4, FA = 64'h20, FD = 64'h40, FS = 64'h80;

    always #10 clk = ~clk;

    ptw_walker u_ptw_walker (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
        .req_write(req_write), .req_user(req_user), .root_base(root_base),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_write(mem_req_write), .mem_req_addr(mem_req_addr),
        .mem_req_wdata(mem_req_wdata), .mem_rsp_valid(mem_rsp_valid),
        .mem_rsp_data(mem_rsp_data), .rsp_valid(rsp_valid), .rsp_paddr(rsp_paddr),
        .rsp_fault(rsp_fault), .rsp_level(rsp_level), .rsp_cause(rsp_cause)
    );

    function automatic logic [63:0] rdm(logic [63:0] a);
        return mem.exists(a) ? mem[a] : 64'h0;
    endfunction

    // memory model with alternating ready
    always @(posedge clk) begin
        mem_rsp_valid <= 1'b0;
        if (mem_req_valid && mem_req_ready) begin
            if (mem_req_write) begin
                mem[mem_req_addr] = mem_req_wdata;
                wr_cnt = wr_cnt + 1;
            end else begin
                mem_rsp_valid <= 1'b1;
                mem_rsp_data  <= rdm(mem_req_addr);
                rd_cnt = rd_cnt + 1;
            end
        end
        mem_req_ready <= ~mem_req_ready;
    end

    function automatic logic [63:0] ea(logic [63:0] base, logic [63:0] va, int lvl);
        return base + (((va >> (39 - 9 * lvl)) & 64'd511) << 3);
    endfunction

    task automatic chk(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic walk(logic [63:0] va, bit wr, bit usr);
        int n;
        rd_cnt = 0;
        wr_cnt = 0;
        @(negedge clk);
        req_vaddr = va; req_write = wr; req_user = usr; req_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        n = 0;
        while (!rsp_valid && n < 200) begin
            @(negedge clk);
            n++;
        end
        got_pa = rsp_paddr; got_fault = rsp_fault; got_level = rsp_level; got_cause = rsp_cause;
        chk(rsp_valid, "R10 response arrived", {63'b0, rsp_valid}, 64'd1);
        @(negedge clk);
        chk(!rsp_valid, "R10 single-cycle response", {63'b0, rsp_valid}, 64'd0);
    endtask

    task automatic chain4(logic [63:0] va, logic [63:0] f0, logic [63:0] f1,
                          logic [63:0] f2, logic [63:0] f3, logic [63:0] frame);
        mem.delete();
        mem[ea(64'h10000, va, 0)] = T1 | f0;
        mem[ea(T1, va, 1)] = T2 | f1;
        mem[ea(T2, va, 2)] = T3 | f2;
        mem[ea(T3, va, 3)] = frame | f3;
    endtask

    task automatic t_reset();
        chk(req_ready == 1'b1, "R9 reset req_ready", {63'b0, req_ready}, 64'd1);
        chk(rsp_valid == 1'b0, "R9 reset rsp_valid", {63'b0, rsp_valid}, 64'd0);
        chk(mem_req_valid == 1'b0, "R9 reset mem_req_valid", {63'b0, mem_req_valid}, 64'd0);
    endtask

    task automatic t_4k_read();
        logic [63:0] va = 64'h0000_1234_5678_9ABC;
        logic [63:0] al = FP | FW | FU | FA;
        chain4(va, al, al, al, al, 64'h77000);
        walk(va, 0, 1);
        chk(got_fault == 0, "R1 4K fault", 64'(got_fault), 0);
        chk(got_pa == 52'h77ABC, "R1 4K paddr", 64'(got_pa), 64'h77ABC);
        chk(rd_cnt == 4, "R1 4K reads", 64'(rd_cnt), 4);
        chk(wr_cnt == 0, "R5 no write when A set", 64'(wr_cnt), 0);
    endtask

    task automatic t_4k_write_clear();
        logic [63:0] va = 64'h0000_0040_2030_1FF8;
        logic [63:0] fl = FP | FW | FU;
        chain4(va, fl, fl, fl, fl, 64'h9_8000);
        walk(va, 1, 0);
        chk(got_pa == 52'h98FF8, "R1 write paddr", 64'(got_pa), 64'h98FF8);
        chk(wr_cnt == 4, "R5 A updates", 64'(wr_cnt), 4);
        chk(rdm(ea(64'h10000, va, 0)) == (T1 | fl | FA), "R5 top entry A", rdm(ea(64'h10000, va, 0)), T1 | fl | FA);
        chk(rdm(ea(T2, va, 2)) == (T3 | fl | FA), "R6 table entry no D", rdm(ea(T2, va, 2)), T3 | fl | FA);
        chk(rdm(ea(T3, va, 3)) == (64'h98000 | fl | FA | FD), "R6 leaf D set", rdm(ea(T3, va, 3)), 64'h98000 | fl | FA | FD);
        // second write: everything already set
        walk(va, 1, 0);
        chk(wr_cnt == 0, "R5 no rewrite", 64'(wr_cnt), 0);
    endtask

    task automatic t_read_no_dirty();
        logic [63:0] va = 64'h0000_0000_0000_5123;
        logic [63:0] al = FP | FW | FU | FA;
        chain4(va, al, al, al, FP | FW | FU, 64'h3_3000);
        walk(va, 0, 0);
        chk(wr_cnt == 1, "R6 read one A write", 64'(wr_cnt), 1);
        chk(rdm(ea(T3, va, 3)) == (64'h33000 | al), "R6 read leaves D clear", rdm(ea(T3, va, 3)), 64'h33000 | al);
    endtask

    task automatic t_2m();
        logic [63:0] va = 64'h0000_7F00_0015_4321;
        logic [63:0] al = FP | FW | FU | FA;
        mem.delete();
        mem[ea(64'h10000, va, 0)] = T1 | al;
        mem[ea(T1, va, 1)] = T2 | al;
        mem[ea(T2, va, 2)] = 64'h40_0000 | al | FS;
        walk(va, 0, 0);
        chk(got_pa == 52'h554321, "R4 2M paddr", 64'(got_pa), 64'h554321);
        chk(rd_cnt == 3, "R4 2M reads", 64'(rd_cnt), 3);
    endtask

    task automatic t_1g();
        logic [63:0] va = 64'hFFFF_8000_2345_6789;
        logic [63:0] al = FP | FW | FU | FA;
        mem.delete();
        mem[ea(64'h10000, va, 0)] = T1 | al;
        mem[ea(T1, va, 1)] = 64'h4000_0000 | al | FS;
        walk(va, 0, 0);
        chk(got_fault == 0, "R2 upper half ok", 64'(got_fault), 0);
        chk(got_pa == 52'h6345_6789, "R4 1G paddr", 64'(got_pa), 64'h63456789);
        chk(rd_cnt == 2, "R4 1G reads", 64'(rd_cnt), 2);
    endtask

    task automatic t_noncanon();
        mem.delete();
        walk(64'h0001_0000_0000_0000, 0, 0);
        chk(got_fault == 1, "R2 GP fault", 64'(got_fault), 1);
        chk(rd_cnt + wr_cnt == 0, "R2 no memory access", 64'(rd_cnt + wr_cnt), 0);
        walk(64'hFFFF_0000_0000_0000, 0, 0);
        chk(got_fault == 1, "R2 GP fault high", 64'(got_fault), 1);
    endtask

    task automatic t_absent();
        logic [63:0] va = 64'h0000_0012_3456_7000;
        logic [63:0] al = FP | FW | FU | FA;
        chain4(va, al, al, FW | FU | FA, al, 64'h1000);
        walk(va, 0, 0);
        chk(got_fault == 2 && got_cause == 1, "R3 not present cause", {got_fault, got_cause}, 64'h9);
        chk(got_level == 2, "R3 level", 64'(got_level), 2);
        chk(rd_cnt == 3 && wr_cnt == 0, "R3 walk stopped", 64'(rd_cnt), 3);
    endtask

    task automatic t_rsvd();
        logic [63:0] va = 64'h0000_0001_0020_0000;
        logic [63:0] al = FP | FW | FU | FA;
        chain4(va, al, al | 64'h0010_0000_0000_0000, al, al, 64'h1000);
        walk(va, 0, 0);
        chk(got_fault == 2 && got_cause == 2, "R7 high reserved", {got_fault, got_cause}, 64'hA);
        chk(got_level == 1, "R7 level", 64'(got_level), 1);
        mem.delete();
        mem[ea(64'h10000, va, 0)] = T1 | al;
        mem[ea(T1, va, 1)] = T2 | al;
        mem[ea(T2, va, 2)] = 64'h40_2000 | al | FS;
        walk(va, 0, 0);
        chk(got_cause == 2 && got_level == 2, "R7 2M low bits", {got_level, got_cause}, 64'hA);
        mem[ea(64'h10000, va, 0)] = T1 | al | FS;
        walk(va, 0, 0);
        chk(got_cause == 2 && got_level == 0, "R7 top size bit", {got_level, got_cause}, 64'h2);
    endtask

    task automatic t_perm();
        logic [63:0] va = 64'h0000_0000_4000_0010;
        logic [63:0] al = FP | FW | FU | FA;
        chain4(va, al, FP | FU | FA, al, FP | FW | FU, 64'h2000);
        walk(va, 1, 0);
        chk(got_fault == 2 && got_cause == 3, "R8 write read-only", {got_fault, got_cause}, 64'hB);
        chk(got_level == 3, "R8 level", 64'(got_level), 3);
        chk(rdm(ea(T3, va, 3)) == (64'h2000 | FP | FW | FU), "R8 leaf untouched", rdm(ea(T3, va, 3)), 64'h2000 | FP | FW | FU);
        chain4(va, al, al, FP | FW | FA, al, 64'h2000);
        walk(va, 0, 1);
        chk(got_cause == 3, "R8 user on supervisor", 64'(got_cause), 3);
        walk(va, 0, 0);
        chk(got_fault == 0 && got_pa == 52'h2010, "R8 supervisor allowed", 64'(got_pa), 64'h2010);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_4k_read();
        t_4k_write_clear();
        t_read_no_dirty();
        t_2m();
        t_1g();
        t_noncanon();
        t_absent();
        t_rsvd();
        t_perm();
        done = 1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule